// File: doc/BRIEF.md
# Data Cache Line Invalidate Sequencer

This block runs a privileged invalidate-one-line operation against a data cache whose lines are held in one of three coherence states: Invalid, Exclusive-clean and Exclusive-dirty. A command carries an effective address. The sequencer first asks the translation unit about that address. The translation unit returns two results: one from a fixed-range (block) translation and one from a page translation. The sequencer checks each result with the write-permission rules that a store would face. If the check passes, it reads the tag array at the address's set index. On a hit it rewrites the matching line's state to Invalid for one cycle, and dirty data is simply dropped with no writeback. It can then ask the system bus to broadcast the invalidate.

Broadcast depends only on a configuration enable. No page attribute plays a part in that choice. No cache-disable or cache-lock condition exists to block the operation. An address that translation reports as lying in a direct-store segment makes the command complete as a no-op. When a protection fault is found, the command ends with a data-storage fault report that carries a cause code, and the cache and the bus are left untouched.

Top module: `blk_inval_ctrl`

## Requirements
- R1: After reset, and whenever no command is in progress, `cmd_ready` is 1 and `xlat_req`, `tag_rd_en`, `lw_en`, `bc_req` and `done` are 0. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` stays 0 from then until `done` has pulsed.
- R2: An accepted command first raises `xlat_req` with `xlat_ea` equal to the command address, and keeps it raised until `xlat_rsp_valid`. The tag array is never read before a clean translation response.
- R3: Protection follows store rules. The range result faults when `rng_hit` is 1 and `rng_wr_ok` is 0. The page result faults when `pg_hit` is 1 and `pg_wr_ok` is 0.
- R4: A fault ends the command with `exc_valid` high in the same cycle as `done`. `exc_cause` is 2'b01 for a range fault and 2'b10 for a page fault. A range fault wins when both faults are present. A faulting command reads no tag, writes no line and makes no broadcast.
- R5: When `xlat_direct` is 1 the command completes with `done` only: no tag read, no line write, no broadcast and no exception, even if protection faults are also flagged.
- R6: After a clean translation the tag array is read at index `ea[OFF_W+IDX_W-1:OFF_W]` (bits 11:5 by default). A hit is `tag_rd_match` together with `tag_rd_state` other than Invalid (2'b00). On a hit `lw_en` pulses for exactly one cycle with that index, with `lw_way` equal to `tag_rd_way`, and with `lw_state` equal to 2'b00. This holds whether the line was Exclusive-clean (2'b01) or Exclusive-dirty (2'b10).
- R7: A miss (no match, or a match on an Invalid line) writes no line state.
- R8: After a clean translation a broadcast is requested exactly when `cfg_bcast_en` is 1, on a hit and on a miss alike.
- R9: `bc_req` stays high, with `bc_ea` stable and equal to the command address, until the cycle in which `bc_ack` is seen.
- R10: Every accepted command produces exactly one single-cycle `done` pulse, and `cmd_ready` returns high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_ea | input | EA_W | Effective address of the line to invalidate |
| cfg_bcast_en | input | 1 | Allow bus broadcast of the invalidate |
| xlat_req | output | 1 | Translation request, held until answered |
| xlat_ea | output | EA_W | Address to translate |
| xlat_rsp_valid | input | 1 | Translation results valid |
| xlat_direct | input | 1 | Address lies in a direct-store segment |
| rng_hit | input | 1 | Range translation matched |
| rng_wr_ok | input | 1 | Range translation allows stores |
| pg_hit | input | 1 | Page translation matched |
| pg_wr_ok | input | 1 | Page translation allows stores |
| tag_rd_en | output | 1 | Tag lookup request, held until answered |
| tag_rd_idx | output | IDX_W | Set index to look up |
| tag_rd_valid | input | 1 | Tag lookup result valid |
| tag_rd_match | input | 1 | A way's tag matched |
| tag_rd_way | input | WAY_W | Matching way |
| tag_rd_state | input | 2 | State of the matching line (00 I, 01 E, 10 M) |
| lw_en | output | 1 | Line state write strobe |
| lw_idx | output | IDX_W | Set index written |
| lw_way | output | WAY_W | Way written |
| lw_state | output | 2 | New line state (always Invalid) |
| bc_req | output | 1 | Bus broadcast request, held until acknowledged |
| bc_ea | output | EA_W | Address broadcast |
| bc_ack | input | 1 | Bus accepted the broadcast |
| done | output | 1 | One-cycle completion pulse |
| exc_valid | output | 1 | Data-storage fault raised by this command |
| exc_cause | output | 2 | Fault cause: 01 range, 10 page |

## Verification
The two protection checks share one translation response, so a range fault and a page fault can land in the same cycle. The direct-store flag can also arrive in that cycle. Directed commands raise both faults together, then the page fault alone, then both faults along with the direct-store flag. Each is judged at the ports: the cause code at `done` must match the fixed ranking, and no tag read, line write or broadcast may appear. Random commands mix all of these flags with hit, miss and broadcast settings, and the bench draws fresh response and acknowledge latencies for each command.

// File: rtl/blk_inval_pkg.sv
package blk_inval_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_XLATE  = 3'd1,
        S_LOOKUP = 3'd2,
        S_UPDATE = 3'd3,
        S_BCAST  = 3'd4,
        S_DONE   = 3'd5
    } seq_state_e;

    localparam logic [1:0] LS_INV   = 2'b00;
    localparam logic [1:0] LS_CLEAN = 2'b01;
    localparam logic [1:0] LS_DIRTY = 2'b10;

    localparam logic [1:0] CAUSE_NONE  = 2'b00;
    localparam logic [1:0] CAUSE_RANGE = 2'b01;
    localparam logic [1:0] CAUSE_PAGE  = 2'b10;

endpackage

// File: rtl/blk_inval_prot.sv
module blk_inval_prot
    import blk_inval_pkg::*;
(
    input  logic       xlat_direct,
    input  logic       rng_hit,
    input  logic       rng_wr_ok,
    input  logic       pg_hit,
    input  logic       pg_wr_ok,
    output logic       noop,
    output logic       fault,
    output logic [1:0] cause
);
    logic rng_viol;
    logic pg_viol;

    // Store permission rule applied to each translation source.
    always_comb begin
        rng_viol = rng_hit && !rng_wr_ok;
        pg_viol  = pg_hit && !pg_wr_ok;
        noop     = xlat_direct;
        fault    = !xlat_direct && (rng_viol || pg_viol);
        if (rng_viol)
            cause = CAUSE_RANGE;
        else if (pg_viol)
            cause = CAUSE_PAGE;
        else
            cause = CAUSE_NONE;
    end

endmodule

// File: rtl/blk_inval_fsm.sv
module blk_inval_fsm
    import blk_inval_pkg::*;
#(
    parameter int EA_W  = 32,
    parameter int OFF_W = 5,
    parameter int IDX_W = 7,
    parameter int WAY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [EA_W-1:0]  cmd_ea,
    input  logic             cfg_bcast_en,
    output logic             xlat_req,
    output logic [EA_W-1:0]  xlat_ea,
    input  logic             xlat_rsp_valid,
    input  logic             prot_noop,
    input  logic             prot_fault,
    input  logic [1:0]       prot_cause,
    output logic             tag_rd_en,
    output logic [IDX_W-1:0] tag_rd_idx,
    input  logic             tag_rd_valid,
    input  logic             tag_rd_match,
    input  logic [WAY_W-1:0] tag_rd_way,
    input  logic [1:0]       tag_rd_state,
    output logic             lw_en,
    output logic [IDX_W-1:0] lw_idx,
    output logic [WAY_W-1:0] lw_way,
    output logic [1:0]       lw_state,
    output logic             bc_req,
    output logic [EA_W-1:0]  bc_ea,
    input  logic             bc_ack,
    output logic             done,
    output logic             exc_valid,
    output logic [1:0]       exc_cause
);

    typedef struct packed {
        seq_state_e       st;
        logic [EA_W-1:0]  ea;
        logic             exc;
        logic [1:0]       cause;
        logic [WAY_W-1:0] way;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      line_hit;

    always_comb begin
        line_hit = tag_rd_match && (tag_rd_state != LS_INV);
        r_d      = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    r_d.st    = S_XLATE;
                    r_d.ea    = cmd_ea;
                    r_d.exc   = 1'b0;
                    r_d.cause = CAUSE_NONE;
                    r_d.way   = '0;
                end
            end
            S_XLATE: begin
                if (xlat_rsp_valid) begin
                    if (prot_noop) begin
                        r_d.st = S_DONE;
                    end else if (prot_fault) begin
                        r_d.st    = S_DONE;
                        r_d.exc   = 1'b1;
                        r_d.cause = prot_cause;
                    end else begin
                        r_d.st = S_LOOKUP;
                    end
                end
            end
            S_LOOKUP: begin
                if (tag_rd_valid) begin
                    if (line_hit) begin
                        r_d.way = tag_rd_way;
                        r_d.st  = S_UPDATE;
                    end else begin
                        r_d.st = cfg_bcast_en ? S_BCAST : S_DONE;
                    end
                end
            end
            S_UPDATE: r_d.st = cfg_bcast_en ? S_BCAST : S_DONE;
            S_BCAST:  if (bc_ack) r_d.st = S_DONE;
            S_DONE:   r_d.st = S_IDLE;
            default:  r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= S_IDLE;
            r_q.ea    <= '0;
            r_q.exc   <= 1'b0;
            r_q.cause <= CAUSE_NONE;
            r_q.way   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cmd_ready  = (r_q.st == S_IDLE);
        xlat_req   = (r_q.st == S_XLATE);
        xlat_ea    = r_q.ea;
        tag_rd_en  = (r_q.st == S_LOOKUP);
        tag_rd_idx = r_q.ea[OFF_W +: IDX_W];
        lw_en      = (r_q.st == S_UPDATE);
        lw_idx     = r_q.ea[OFF_W +: IDX_W];
        lw_way     = r_q.way;
        lw_state   = LS_INV;
        bc_req     = (r_q.st == S_BCAST);
        bc_ea      = r_q.ea;
        done       = (r_q.st == S_DONE);
        exc_valid  = done && r_q.exc;
        exc_cause  = done ? r_q.cause : CAUSE_NONE;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !xlat_req && !tag_rd_en && !lw_en && !bc_req && !done);

    // R2
    lookup_after_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_rd_en) |-> $past(xlat_req) && $past(xlat_rsp_valid));

    // R4
    exc_cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> done && $countones(exc_cause) == 1);

    // R6
    line_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en |=> !lw_en);

    // R9
    bcast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_req && !bc_ack |=> bc_req && $stable(bc_ea));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && cmd_ready);

endmodule

// File: rtl/blk_inval_ctrl.sv
module blk_inval_ctrl
    import blk_inval_pkg::*;
#(
    parameter int EA_W       = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [EA_W-1:0]  cmd_ea,
    input  logic             cfg_bcast_en,
    output logic             xlat_req,
    output logic [EA_W-1:0]  xlat_ea,
    input  logic             xlat_rsp_valid,
    input  logic             xlat_direct,
    input  logic             rng_hit,
    input  logic             rng_wr_ok,
    input  logic             pg_hit,
    input  logic             pg_wr_ok,
    output logic             tag_rd_en,
    output logic [IDX_W-1:0] tag_rd_idx,
    input  logic             tag_rd_valid,
    input  logic             tag_rd_match,
    input  logic [WAY_W-1:0] tag_rd_way,
    input  logic [1:0]       tag_rd_state,
    output logic             lw_en,
    output logic [IDX_W-1:0] lw_idx,
    output logic [WAY_W-1:0] lw_way,
    output logic [1:0]       lw_state,
    output logic             bc_req,
    output logic [EA_W-1:0]  bc_ea,
    input  logic             bc_ack,
    output logic             done,
    output logic             exc_valid,
    output logic [1:0]       exc_cause
);

    logic       p_noop;
    logic       p_fault;
    logic [1:0] p_cause;

    blk_inval_prot u_prot (
        .xlat_direct (xlat_direct),
        .rng_hit     (rng_hit),
        .rng_wr_ok   (rng_wr_ok),
        .pg_hit      (pg_hit),
        .pg_wr_ok    (pg_wr_ok),
        .noop        (p_noop),
        .fault       (p_fault),
        .cause       (p_cause)
    );

    blk_inval_fsm #(
        .EA_W  (EA_W),
        .OFF_W (OFF_W),
        .IDX_W (IDX_W),
        .WAY_W (WAY_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_ready      (cmd_ready),
        .cmd_ea         (cmd_ea),
        .cfg_bcast_en   (cfg_bcast_en),
        .xlat_req       (xlat_req),
        .xlat_ea        (xlat_ea),
        .xlat_rsp_valid (xlat_rsp_valid),
        .prot_noop      (p_noop),
        .prot_fault     (p_fault),
        .prot_cause     (p_cause),
        .tag_rd_en      (tag_rd_en),
        .tag_rd_idx     (tag_rd_idx),
        .tag_rd_valid   (tag_rd_valid),
        .tag_rd_match   (tag_rd_match),
        .tag_rd_way     (tag_rd_way),
        .tag_rd_state   (tag_rd_state),
        .lw_en          (lw_en),
        .lw_idx         (lw_idx),
        .lw_way         (lw_way),
        .lw_state       (lw_state),
        .bc_req         (bc_req),
        .bc_ea          (bc_ea),
        .bc_ack         (bc_ack),
        .done           (done),
        .exc_valid      (exc_valid),
        .exc_cause      (exc_cause)
    );

    // R4
    fault_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req && xlat_rsp_valid && p_fault |-> p_cause != 2'b00);

endmodule

// File: tb/sim_blk_inval_ctrl.sv
module sim_blk_inval_ctrl;

    localparam int EA_W = 32;
    localparam int OFF_W = 5;
    localparam int IDX_W = 7;
    localparam int WAY_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             cmd_valid = 0, cmd_ready;
    logic [EA_W-1:0]  cmd_ea = '0;
    logic             cfg_bcast_en = 0;
    logic             xlat_req;
    logic [EA_W-1:0]  xlat_ea;
    logic             xlat_rsp_valid = 0, xlat_direct = 0;
    logic             rng_hit = 0, rng_wr_ok = 0, pg_hit = 0, pg_wr_ok = 0;
    logic             tag_rd_en;
    logic [IDX_W-1:0] tag_rd_idx;
    logic             tag_rd_valid = 0, tag_rd_match = 0;
    logic [WAY_W-1:0] tag_rd_way = '0;
    logic [1:0]       tag_rd_state = '0;
    logic             lw_en;
    logic [IDX_W-1:0] lw_idx;
    logic [WAY_W-1:0] lw_way;
    logic [1:0]       lw_state;
    logic             bc_req;
    logic [EA_W-1:0]  bc_ea;
    logic             bc_ack = 0;
    logic             done, exc_valid;
    logic [1:0]       exc_cause;

    blk_inval_ctrl u0 (.*);

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic run_op(input logic [EA_W-1:0] ea, input bit ds,
                          input bit rh, input bit rok, input bit ph, input bit pok,
                          input bit mt, input logic [WAY_W-1:0] way, input logic [1:0] lst,
                          input bit bcen, input int xl, input int tl, input int bl);
        bit exp_fault, exp_lookup, exp_hit, exp_bc;
        logic [1:0] exp_cause;
        int xc = 0, tc = 0, bcnt = 0;
        int xlat_seen = 0, tag_seen = 0, lw_n = 0, bc_n = 0;
        bit xea_ok = 1, idx_ok = 1, lw_ok = 1, bea_ok = 1, busy_ok = 1, got_done = 0;
        bit ev = 0;
        logic [1:0] ec = 0;
        logic [IDX_W-1:0] exp_idx;

        exp_idx    = ea[OFF_W +: IDX_W];
        exp_cause  = (rh && !rok) ? 2'b01 : ((ph && !pok) ? 2'b10 : 2'b00);
        exp_fault  = !ds && (exp_cause != 2'b00);
        exp_lookup = !ds && !exp_fault;
        exp_hit    = exp_lookup && mt && (lst != 2'b00);
        exp_bc     = exp_lookup && bcen;

        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "ready before command", cmd_ready, 1);
        cfg_bcast_en = bcen; xlat_direct = ds;
        rng_hit = rh; rng_wr_ok = rok; pg_hit = ph; pg_wr_ok = pok;
        tag_rd_match = mt; tag_rd_way = way; tag_rd_state = lst;
        cmd_valid = 1; cmd_ea = ea;
        @(negedge clk);
        cmd_valid = 0; cmd_ea = $urandom;
        for (int cyc = 0; cyc < 300; cyc++) begin
            if (done) begin
                got_done = 1; ev = exc_valid; ec = exc_cause;
                xlat_rsp_valid = 0; tag_rd_valid = 0; bc_ack = 0;
                break;
            end
            if (cmd_ready) busy_ok = 0;
            if (xlat_req) begin
                xlat_seen++;
                if (xlat_ea != ea) xea_ok = 0;
            end
            if (tag_rd_en) begin
                tag_seen++;
                if (tag_rd_idx != exp_idx) idx_ok = 0;
            end
            if (lw_en) begin
                lw_n++;
                if (lw_idx != exp_idx || lw_way != way || lw_state != 2'b00) lw_ok = 0;
            end
            if (bc_req) begin
                bc_n++;
                if (bc_ea != ea) bea_ok = 0;
            end
            xlat_rsp_valid = xlat_req && (xc == xl);
            if (xlat_req) xc++;
            tag_rd_valid = tag_rd_en && (tc == tl);
            if (tag_rd_en) tc++;
            bc_ack = bc_req && (bcnt == bl);
            if (bc_req) bcnt++;
            @(negedge clk);
        end
        chk(got_done, "R10", "done reached", got_done, 1);
        chk(busy_ok, "R1", "ready low while busy", busy_ok, 1);
        chk(xea_ok && xlat_seen == xl + 1, "R2", "translation request cycles", xlat_seen, xl + 1);
        chk(ev == exp_fault, "R4", "exception flag", ev, exp_fault);
        chk(ec == (exp_fault ? exp_cause : 2'b00), "R4", "exception cause", ec,
            exp_fault ? exp_cause : 2'b00);
        chk(idx_ok && tag_seen == (exp_lookup ? tl + 1 : 0), ds ? "R5" : "R6",
            "tag lookup cycles", tag_seen, exp_lookup ? tl + 1 : 0);
        chk(lw_ok && lw_n == (exp_hit ? 1 : 0), exp_hit ? "R6" : "R7",
            "line write count", lw_n, exp_hit ? 1 : 0);
        chk(bea_ok && bc_n == (exp_bc ? bl + 1 : 0), exp_bc ? "R9" : "R8",
            "broadcast request cycles", bc_n, exp_bc ? bl + 1 : 0);
        @(negedge clk);
        chk(!done && cmd_ready, "R10", "single done pulse", done, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
        chk(!xlat_req && !tag_rd_en && !lw_en && !bc_req && !done, "R1", "reset requests",
            {xlat_req, tag_rd_en, lw_en, bc_req, done}, 0);

        // R6 hit on a clean line, then on a dirty line
        run_op(32'h0000_0A60, 0, 1, 1, 1, 1, 1, 3'd5, 2'b01, 0, 0, 0, 0);
        run_op(32'h1234_5FE0, 0, 0, 0, 1, 1, 1, 3'd7, 2'b10, 0, 2, 1, 0);
        // R7 match on Invalid line counts as miss; R8 broadcast on miss
        run_op(32'h0000_0040, 0, 0, 0, 1, 1, 1, 3'd2, 2'b00, 1, 1, 0, 3);
        run_op(32'h0000_0080, 0, 0, 0, 1, 1, 0, 3'd0, 2'b01, 0, 0, 2, 0);
        // R9 hit with broadcast and slow acknowledge
        run_op(32'hFFFF_FFE0, 0, 1, 1, 0, 0, 1, 3'd1, 2'b10, 1, 0, 0, 6);
        // R4 both faults together: range cause wins
        run_op(32'h0000_1000, 0, 1, 0, 1, 0, 1, 3'd0, 2'b10, 1, 1, 0, 0);
        // R3 page fault alone
        run_op(32'h0000_2000, 0, 0, 0, 1, 0, 1, 3'd0, 2'b01, 1, 0, 0, 0);
        // R3 range hit with write allowed, page matched but write denied
        run_op(32'h0000_3000, 0, 1, 1, 1, 0, 1, 3'd4, 2'b01, 0, 0, 0, 0);
        // R5 direct-store with both faults and a hit
        run_op(32'h0000_4000, 1, 1, 0, 1, 0, 1, 3'd6, 2'b10, 1, 3, 0, 0);
        run_op(32'h0000_5000, 1, 0, 0, 0, 0, 1, 3'd6, 2'b01, 1, 0, 0, 0);

        for (int i = 0; i < 60; i++) begin
            run_op($urandom, ($urandom % 6) == 0, $urandom, $urandom, $urandom,
                   ($urandom % 4) != 0, $urandom, 3'($urandom), 2'($urandom % 3),
                   $urandom, $urandom % 4, $urandom % 4, $urandom % 5);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule